// File: doc/BRIEF.md
# Bus-Width Matching Stage for a 36-bit FIFO

This stage sits on both sides of a FIFO core whose storage word is 36 bits wide. It lets the external write port and the external read port run narrower than the storage word. On the write side it collects two 18-bit or four 9-bit input words into one 36-bit entry, and it hands that entry to the core only once the entry is complete. On the read side it breaks one 36-bit head entry into two 18-bit or four 9-bit output words. It tells the core to drop the entry only after the last of those output words has been taken. The stage does not hold storage, flags or clock-domain crossing logic.

The width pairing and the byte order are taken from configuration pins while master reset is held. They stay fixed until the next master reset. The byte order setting chooses whether the most significant or the least significant sub-word moves first, on both sides. A synchronous partial reset discards any half-built write entry and rewinds both sub-word counters, and it keeps the configuration. Narrow ports use the low bits of the 36-bit data buses.

Top module: `fifo_width_adapter`

## Requirements
- R1: Mode code 0 (36 in, 36 out) passes data straight through. Each write gives `core_we` with `core_wdata` equal to `in_data` in the same cycle. Each read with `core_empty` low gives `core_re`, and `out_data` equals `core_rdata`.
- R2: Mode code 1 (36 in, 18 out) reads each entry as two 18-bit words on `out_data[17:0]`, with bits 35:18 at zero. `core_re` is asserted only on the second read.
- R3: Mode code 2 (36 in, 9 out) reads each entry as four 9-bit words on `out_data[8:0]`, with the upper bits at zero. `core_re` is asserted only on the fourth read.
- R4: Mode code 3 (18 in, 36 out) packs two writes taken from `in_data[17:0]` into one entry. `core_we` is asserted only in the cycle of the second write, and `in_data[35:18]` is ignored.
- R5: Mode code 4 (9 in, 36 out) packs four writes taken from `in_data[8:0]` into one entry. `core_we` is asserted only in the cycle of the fourth write, and `in_data[35:9]` is ignored.
- R6: With big-endian set, the first sub-word written or read occupies the most significant lane of the entry. With it clear, the first sub-word occupies the least significant lane. The following sub-words fill the adjacent lanes in turn.
- R7: `cfg_mode` and `cfg_big_endian` are sampled only on clock edges where `rst_n` is low. Changes to them at other times have no effect.
- R8: A high `clr` on a clock edge discards a partly assembled write entry and returns both sub-word counters to the first sub-word. The configuration and the core's contents are unchanged.
- R9: A read request while `core_empty` is high is ignored. `core_re` stays low and the read sub-word position does not advance.
- R10: Mode codes 5, 6 and 7 behave exactly as mode code 0.
- R11: After master reset, `core_we` and `core_re` are low while no write or read is requested, and both counters start at the first sub-word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous master reset, active low; loads configuration |
| clr | input | 1 | Synchronous partial reset, active high |
| cfg_mode | input | 3 | Width pairing code, sampled during master reset |
| cfg_big_endian | input | 1 | 1: most significant sub-word first; sampled during master reset |
| in_we | input | 1 | External write strobe |
| in_data | input | 36 | External write data; narrow modes use the low bits |
| core_we | output | 1 | Commit a full entry to the core |
| core_wdata | output | 36 | Entry being committed |
| core_empty | input | 1 | Core has no entry at its head |
| core_rdata | input | 36 | Core head entry |
| out_re | input | 1 | External read strobe |
| out_data | output | 36 | Current output sub-word, zero-extended |
| core_re | output | 1 | Release the head entry |

## Verification
Every width code, including the three unused ones, is run with both byte orders under random interleavings of writes, reads and partial resets. The configuration pins are scrambled on every cycle after reset. This separates lane-placement errors from commit-timing errors and from configuration leaks. Directed sequences then fix known lane patterns in both orders, which shows a swapped order even where a random model might share the mistake. Further directed cases cover a partial reset in the middle of an entry on both sides, and reads attempted against an empty core before data arrives.

// File: rtl/bw_pkg.sv
package bw_pkg;

   typedef enum logic [2:0] {
      WM_FULL        = 3'd0,
      WM_OUT_HALF    = 3'd1,
      WM_OUT_QUARTER = 3'd2,
      WM_IN_HALF     = 3'd3,
      WM_IN_QUARTER  = 3'd4
   } width_mode_e;

   // log2 of sub-words per entry on the write side
   function automatic logic [1:0] in_shift(input logic [2:0] m);
      case (m)
         WM_IN_HALF:    return 2'd1;
         WM_IN_QUARTER: return 2'd2;
         default:       return 2'd0;
      endcase
   endfunction

   // log2 of sub-words per entry on the read side
   function automatic logic [1:0] out_shift(input logic [2:0] m);
      case (m)
         WM_OUT_HALF:    return 2'd1;
         WM_OUT_QUARTER: return 2'd2;
         default:        return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/bw_pack.sv
module bw_pack #(
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [1:0]        rsh,
   input  logic              big_end,
   input  logic              in_we,
   input  logic [WORD_W-1:0] in_data,
   output logic              core_we,
   output logic [WORD_W-1:0] core_wdata
);
   localparam int OFS_W = $clog2(WORD_W * 4);

   logic [1:0]        cnt;
   logic [WORD_W-1:0] acc;
   logic [2:0]        nsub;
   logic              last;
   logic [2:0]        lane;
   logic [OFS_W-1:0]  lw;
   logic [OFS_W-1:0]  ofs;
   logic [WORD_W-1:0] mask;
   logic [WORD_W-1:0] placed;

   always_comb begin
      nsub   = 3'd1 << rsh;
      last   = ({1'b0, cnt} == (nsub - 3'd1));
      lane   = big_end ? (nsub - 3'd1 - {1'b0, cnt}) : {1'b0, cnt};
      lw     = OFS_W'(WORD_W >> rsh);
      ofs    = OFS_W'(lane) * lw;
      mask   = {WORD_W{1'b1}} >> (WORD_W - 32'(lw));
      placed = (in_data & mask) << ofs;
   end

   assign core_we    = in_we & last;
   assign core_wdata = acc | placed;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
         acc <= '0;
      end else if (in_we) begin
         if (last) begin
            cnt <= '0;
            acc <= '0;
         end else begin
            cnt <= cnt + 2'd1;
            acc <= acc | placed;
         end
      end
   end

   // R4
   wr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_we && !core_we && !clr) |=> (cnt == $past(cnt) + 2'd1));
   // R5
   wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt} < nsub));
   // R8
   wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == 2'd0 && acc == '0));

endmodule

// File: rtl/bw_unpack.sv
module bw_unpack #(
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [1:0]        rsh,
   input  logic              big_end,
   input  logic              out_re,
   input  logic              core_empty,
   input  logic [WORD_W-1:0] core_rdata,
   output logic [WORD_W-1:0] out_data,
   output logic              core_re
);
   localparam int OFS_W = $clog2(WORD_W * 4);

   logic [1:0]        cnt;
   logic [2:0]        nsub;
   logic              last;
   logic              take;
   logic [2:0]        lane;
   logic [OFS_W-1:0]  lw;
   logic [OFS_W-1:0]  ofs;
   logic [WORD_W-1:0] mask;

   always_comb begin
      nsub = 3'd1 << rsh;
      last = ({1'b0, cnt} == (nsub - 3'd1));
      take = out_re & ~core_empty;
      lane = big_end ? (nsub - 3'd1 - {1'b0, cnt}) : {1'b0, cnt};
      lw   = OFS_W'(WORD_W >> rsh);
      ofs  = OFS_W'(lane) * lw;
      mask = {WORD_W{1'b1}} >> (WORD_W - 32'(lw));
   end

   assign out_data = (core_rdata >> ofs) & mask;
   assign core_re  = take & last;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt <= '0;
      else if (take)     cnt <= last ? 2'd0 : cnt + 2'd1;
   end

   // R9
   rd_hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_empty && !clr) |=> $stable(cnt));
   // R2
   rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt} < nsub));
   // R8
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == 2'd0));

endmodule

// File: rtl/fifo_width_adapter.sv
module fifo_width_adapter #(
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [2:0]        cfg_mode,
   input  logic              cfg_big_endian,
   input  logic              in_we,
   input  logic [WORD_W-1:0] in_data,
   output logic              core_we,
   output logic [WORD_W-1:0] core_wdata,
   input  logic              core_empty,
   input  logic [WORD_W-1:0] core_rdata,
   input  logic              out_re,
   output logic [WORD_W-1:0] out_data,
   output logic              core_re
);
   import bw_pkg::*;

   generate
      if (WORD_W % 4 != 0 || WORD_W < 4) begin : g_bad_width
         $error("WORD_W must be a positive multiple of 4");
      end
   endgenerate

   logic [2:0] mode_q;
   logic       be_q;
   logic [1:0] rsh_in;
   logic [1:0] rsh_out;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= cfg_mode;
         be_q   <= cfg_big_endian;
      end
   end

   assign rsh_in  = in_shift(mode_q);
   assign rsh_out = out_shift(mode_q);

   bw_pack #(.WORD_W(WORD_W)) i_pack (
      .clk(clk), .rst_n(rst_n), .clr(clr), .rsh(rsh_in), .big_end(be_q),
      .in_we(in_we), .in_data(in_data),
      .core_we(core_we), .core_wdata(core_wdata)
   );

   bw_unpack #(.WORD_W(WORD_W)) i_unpack (
      .clk(clk), .rst_n(rst_n), .clr(clr), .rsh(rsh_out), .big_end(be_q),
      .out_re(out_re), .core_empty(core_empty), .core_rdata(core_rdata),
      .out_data(out_data), .core_re(core_re)
   );

   // R7
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($stable(mode_q) && $stable(be_q)));

endmodule

// File: tb/test_fifo_width_adapter.sv
module test_fifo_width_adapter;

   logic        clk = 1'b0;
   logic        rst_n, clr, cfg_big_endian, in_we, core_we, core_empty, out_re, core_re;
   logic [2:0]  cfg_mode;
   logic [35:0] in_data, core_wdata, core_rdata, out_data;

   always #5 clk = ~clk;

   fifo_width_adapter i_fifo_width_adapter (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_mode(cfg_mode),
      .cfg_big_endian(cfg_big_endian), .in_we(in_we), .in_data(in_data),
      .core_we(core_we), .core_wdata(core_wdata), .core_empty(core_empty),
      .core_rdata(core_rdata), .out_re(out_re), .out_data(out_data),
      .core_re(core_re)
   );

   int          vectors = 0;
   int          miscompares = 0;
   bit          done = 0;
   logic [35:0] q[$];
   int          m_mode, wc, rc;
   bit          m_be;
   logic [35:0] acc;
   logic [35:0] last_wdata, last_out;
   logic        last_we;

   function automatic int rin(int m);
      return (m == 3) ? 2 : (m == 4) ? 4 : 1;
   endfunction
   function automatic int rout(int m);
      return (m == 1) ? 2 : (m == 2) ? 4 : 1;
   endfunction
   function automatic logic [35:0] lmask(int w);
      return {36{1'b1}} >> (36 - w);
   endfunction
   function automatic string wtag(int m);
      return (m == 3) ? "R4" : (m == 4) ? "R5" : (m >= 5) ? "R10" : "R1";
   endfunction
   function automatic string rtag(int m);
      return (m == 1) ? "R2" : (m == 2) ? "R3" : (m >= 5) ? "R10" : "R1";
   endfunction

   task automatic chk(string r, logic [35:0] act, logic [35:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic refresh();
      core_empty = (q.size() == 0);
      core_rdata = (q.size() > 0) ? q[0] : 36'd0;
   endtask

   task automatic do_reset(int mode, bit be);
      @(negedge clk);
      rst_n = 0; clr = 0; in_we = 0; out_re = 0; in_data = '0;
      cfg_mode = 3'(mode); cfg_big_endian = be;
      q.delete(); refresh();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1;
      m_mode = mode; m_be = be; wc = 0; rc = 0; acc = '0;
      #2;
      // R11
      chk("R11", {35'd0, core_we}, 36'd0);
      chk("R11", {35'd0, core_re}, 36'd0);
      @(negedge clk);
   endtask

   // starts and ends at a falling edge
   task automatic op(bit we, logic [35:0] d, bit re, bit doclr);
      int ri, ro, wi, wo, pos;
      logic [35:0] placed, expd;
      bit exp_we, exp_re, had;
      in_we = we; in_data = d; out_re = re; clr = doclr;
      cfg_mode = 3'($urandom); cfg_big_endian = 1'($urandom);  // R7 scramble
      #2;
      ri = rin(m_mode); wi = 36 / ri;
      ro = rout(m_mode); wo = 36 / ro;
      exp_we = 0; placed = '0;
      if (we) begin
         pos = m_be ? (ri - 1 - wc) : wc;
         placed = (d & lmask(wi)) << (pos * wi);
         exp_we = (wc == ri - 1);
         if (exp_we) chk(wtag(m_mode), core_wdata, acc | placed);
      end
      chk(we ? wtag(m_mode) : "R11", {35'd0, core_we}, {35'd0, exp_we});
      last_we = core_we; last_wdata = core_wdata;
      had = (q.size() > 0);
      exp_re = 0;
      if (had) begin
         pos = m_be ? (ro - 1 - rc) : rc;
         expd = (q[0] >> (pos * wo)) & lmask(wo);
         chk(rtag(m_mode), out_data, expd);
         exp_re = re && (rc == ro - 1);
         chk(rtag(m_mode), {35'd0, core_re}, {35'd0, exp_re});
      end else begin
         chk("R9", {35'd0, core_re}, 36'd0);
      end
      last_out = out_data;
      @(posedge clk);
      #1;
      if (doclr) begin
         wc = 0; rc = 0; acc = '0;
      end else begin
         if (re && had) begin
            if (rc == ro - 1) begin rc = 0; void'(q.pop_front()); end
            else rc++;
         end
         if (we) begin
            if (exp_we) begin q.push_back(acc | placed); acc = '0; wc = 0; end
            else begin acc = acc | placed; wc++; end
         end
      end
      refresh();
      in_we = 0; out_re = 0; clr = 0;
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; clr = 0; in_we = 0; out_re = 0; in_data = '0;
      cfg_mode = '0; cfg_big_endian = 0;
      refresh();

      // R6: little-endian packing, 9-bit in
      do_reset(4, 0);
      op(1, 36'hFFFFFFE01, 0, 0); op(1, 36'h000000002, 0, 0); op(1, 36'h000000003, 0, 0);
      op(1, 36'h000000004, 0, 0);
      chk("R6", last_wdata, {9'h004, 9'h003, 9'h002, 9'h001});
      // R6: big-endian packing, 9-bit in
      do_reset(4, 1);
      op(1, 36'h000000001, 0, 0); op(1, 36'h000000002, 0, 0); op(1, 36'h000000003, 0, 0);
      op(1, 36'h000000004, 0, 0);
      chk("R6", last_wdata, {9'h001, 9'h002, 9'h003, 9'h004});
      // R6: big-endian unpacking, 9-bit out
      do_reset(2, 1);
      op(1, {9'h1A1, 9'h0B2, 9'h0C3, 9'h0D4}, 0, 0);
      op(0, '0, 1, 0);
      chk("R6", last_out, 36'h1A1);
      // R8: write-side partial reset, 18-bit in, little-endian
      do_reset(3, 0);
      op(1, 36'h00000AAAA, 0, 0);
      op(0, '0, 0, 1);
      op(1, 36'h000001111, 0, 0); op(1, 36'h000002222, 0, 0);
      chk("R8", last_wdata, {18'h02222, 18'h01111});
      // R8: read-side partial reset rewinds to first half, big-endian
      do_reset(1, 1);
      op(1, 36'h123456789, 0, 0);
      op(0, '0, 1, 0);
      op(0, '0, 0, 1);
      op(0, '0, 1, 0);
      chk("R8", last_out, 36'(36'h123456789 >> 18));
      // R9: reads against empty core are ignored
      do_reset(2, 0);
      op(0, '0, 1, 0); op(0, '0, 1, 0);
      op(1, 36'h987654321, 0, 0);
      op(0, '0, 1, 0);
      chk("R9", last_out, 36'h987654321 & 36'h1FF);
      // R7: config pins changed after reset do not alter pass-through
      do_reset(0, 0);
      op(1, 36'h00000000F, 0, 0);
      chk("R7", {35'd0, last_we}, 36'd1);

      // random sweep over every code and byte order
      for (int m = 0; m < 8; m++) begin
         for (int b = 0; b < 2; b++) begin
            do_reset(m, 1'(b));
            for (int k = 0; k < 60; k++) begin
               if ($urandom % 16 == 0) op(0, '0, 0, 1);
               else op(1'($urandom), 36'({$urandom, $urandom}), 1'($urandom), 0);
            end
         end
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule